// File: doc/BRIEF.md
# Event Number Resynchronizer

This block sits on one front-end readout channel and decides, per arriving front-end event header, how that event lines up against the event the local trigger system expects. It sees the number and type (calibration or normal) of the local trigger event, the number of the current front-end event, and the number and type of the front-end event queued behind it. From these it picks one of four actions: accept the current event, skip it (the front end is ahead of a stale event), pad an empty event in its place (the front end has lost an event), or read it as-is when no recovery rule applies. It moves no data. A downstream event builder acts on the decision.

Recovery looks one event ahead and uses a window of 16 events. Both the window and the low-order consistency checks use the four least significant bits of the event numbers. Each decision is registered and comes out one clock after the header strobe. Two saturating counters record how often skip and pad were chosen. A synchronisation control word turns the recovery off. When it is non-zero, every event is accepted and neither counter moves.

Top module: `evn_resync`

## Requirements
- R1: During and after synchronous reset, `dec_valid` is 0, `dec` is 0, and both `skip_count` and `pad_count` are 0.
- R2: With `sync_ctrl` zero, a header whose `cur_evn` equals `loc_evn` is accepted (`dec` = 4'b0001).
- R3: Otherwise, the header is accepted when `cur_evn[3:0]` equals `loc_evn[3:0]` and `cur_evn[3:0]` is the previous header's `cur_evn[3:0]` plus one (modulo 16). The first header after reset has no predecessor, so this rule cannot fire for it.
- R4: Otherwise, when `nxt_cal` differs from `loc_cal`, the header is accepted.
- R5: Otherwise, the header is skipped (`dec` = 4'b0010) when (`loc_evn` − `nxt_evn`) mod 2^24 is below 16 and `nxt_evn[3:0]` equals `cur_evn[3:0]` + 1 (modulo 16).
- R6: Otherwise, an empty event is padded (`dec` = 4'b0100) when (`nxt_evn` − `loc_evn`) mod 2^24 is below 16 and the same next-event LSB step holds.
- R7: Every remaining header is read as-is (`dec` = 4'b1000).
- R8: A header strobed on `hdr_valid` at one rising edge produces `dec_valid` = 1 and exactly one bit set in `dec` after that edge, for one cycle.
- R9: When `sync_ctrl` is non-zero, every header is accepted and neither counter changes.
- R10: `skip_count` and `pad_count` each rise by one in the same cycle their decision is presented. Each stops at its all-ones maximum.
- R11: Without `hdr_valid`, `dec_valid` and `dec` are 0 one cycle later and both counters hold.
- R12: The window distances of R5 and R6 are taken modulo 2^24, so they stay correct across the wrap of the event number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_ctrl | input | SYNC_W | Synchronisation control word; recovery is active only when zero |
| hdr_valid | input | 1 | Strobe: a front-end header is presented this cycle |
| loc_evn | input | EVN_W | Local trigger event number |
| loc_cal | input | 1 | Local trigger event is a calibration event |
| cur_evn | input | EVN_W | Current front-end event number |
| nxt_evn | input | EVN_W | Next front-end event number |
| nxt_cal | input | 1 | Next front-end event is a calibration event |
| dec_valid | output | 1 | Decision present |
| dec | output | 4 | One-hot decision: bit0 accept, bit1 skip, bit2 pad, bit3 read |
| skip_count | output | CNT_W | Saturating count of skip decisions |
| pad_count | output | CNT_W | Saturating count of pad decisions |

## Verification
Every result is due exactly one rising edge after the header strobe. The decision, its valid flag and the counter increment all land on that same edge, and the record of the previous header's low bits updates there too. The bench drives each header on a falling edge and lowers the strobe on the next falling edge. It compares the decision and both counters at that point, one edge after the strobe. One further idle cycle later, it confirms that the decision has cleared and the counters have held. Expected values come from an arithmetic model of the rule order that tracks the previous low bits itself. The sweep covers local numbers at and near the 24-bit wrap, current offsets that do and do not share the local LSBs, next offsets across both sides of the window, both type relations, and a primed and unprimed predecessor. A narrow counter is used so that saturation is reached.

// File: rtl/evr_pkg.sv
package evr_pkg;

    // One-hot decision codes presented on the dec output
    typedef enum logic [3:0] {
        DEC_NONE   = 4'b0000,
        DEC_ACCEPT = 4'b0001,
        DEC_SKIP   = 4'b0010,
        DEC_PAD    = 4'b0100,
        DEC_READ   = 4'b1000
    } decision_e;

    // Which rule produced an accept; kept for the decision pipeline
    typedef enum logic [2:0] {
        WHY_NONE,
        WHY_EXACT,
        WHY_LSB_STEP,
        WHY_TYPE,
        WHY_MODE_OFF
    } accept_why_e;

    typedef struct packed {
        decision_e   dec;
        accept_why_e why;
    } verdict_t;

    localparam int unsigned DEF_EVN_W  = 24;
    localparam int unsigned DEF_CNT_W  = 32;
    localparam int unsigned DEF_WIN    = 16;
    localparam int unsigned DEF_SYNC_W = 32;

endpackage

// File: rtl/evr_lsb_track.sv
module evr_lsb_track #(
    parameter int unsigned LSB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_valid,
    input  logic [LSB_W-1:0] cur_lsb,
    output logic             step_ok
);
    logic [LSB_W-1:0] prev_lsb;
    logic             prev_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lsb  <= '0;
            prev_seen <= 1'b0;
        end else if (hdr_valid) begin
            prev_lsb  <= cur_lsb;
            prev_seen <= 1'b1;
        end
    end

    // Current header advanced the low bits by exactly one from the last one
    assign step_ok = prev_seen && (cur_lsb == LSB_W'(prev_lsb + 1'b1));

endmodule

// File: rtl/evr_decide.sv
module evr_decide
    import evr_pkg::*;
#(
    parameter int unsigned EVN_W  = 24,
    parameter int unsigned WIN    = 16,
    parameter int unsigned SYNC_W = 32
) (
    input  logic [SYNC_W-1:0] sync_ctrl,
    input  logic [EVN_W-1:0]  loc_evn,
    input  logic              loc_cal,
    input  logic [EVN_W-1:0]  cur_evn,
    input  logic [EVN_W-1:0]  nxt_evn,
    input  logic              nxt_cal,
    input  logic              prev_step_ok,
    output verdict_t          verdict
);
    localparam int unsigned LSB_W = $clog2(WIN);

    logic [EVN_W-1:0] dist_back;
    logic [EVN_W-1:0] dist_fwd;
    logic             in_back;
    logic             in_fwd;
    logic             nxt_step;
    logic             exact;
    logic             lsb_same;
    logic             recovery_on;

    always_comb begin
        dist_back   = loc_evn - nxt_evn;
        dist_fwd    = nxt_evn - loc_evn;
        in_back     = dist_back < EVN_W'(WIN);
        in_fwd      = dist_fwd < EVN_W'(WIN);
        nxt_step    = nxt_evn[LSB_W-1:0] == LSB_W'(cur_evn[LSB_W-1:0] + 1'b1);
        exact       = cur_evn == loc_evn;
        lsb_same    = cur_evn[LSB_W-1:0] == loc_evn[LSB_W-1:0];
        recovery_on = sync_ctrl == '0;

        verdict.dec = DEC_READ;
        verdict.why = WHY_NONE;
        if (!recovery_on) begin
            verdict.dec = DEC_ACCEPT;
            verdict.why = WHY_MODE_OFF;
        end else if (exact) begin
            verdict.dec = DEC_ACCEPT;
            verdict.why = WHY_EXACT;
        end else if (lsb_same && prev_step_ok) begin
            verdict.dec = DEC_ACCEPT;
            verdict.why = WHY_LSB_STEP;
        end else if (nxt_cal != loc_cal) begin
            verdict.dec = DEC_ACCEPT;
            verdict.why = WHY_TYPE;
        end else if (in_back && nxt_step) begin
            verdict.dec = DEC_SKIP;
        end else if (in_fwd && nxt_step) begin
            verdict.dec = DEC_PAD;
        end
    end

endmodule

// File: rtl/evr_sat_cnt.sv
module evr_sat_cnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end

    AST_CNT_STICKS_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (count == TOP) |=> (count == TOP)); // R10
    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + 1'b1)); // R10

endmodule

// File: rtl/evn_resync.sv
module evn_resync
    import evr_pkg::*;
#(
    parameter int unsigned EVN_W  = DEF_EVN_W,
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned WIN    = DEF_WIN,
    parameter int unsigned SYNC_W = DEF_SYNC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SYNC_W-1:0] sync_ctrl,
    input  logic              hdr_valid,
    input  logic [EVN_W-1:0]  loc_evn,
    input  logic              loc_cal,
    input  logic [EVN_W-1:0]  cur_evn,
    input  logic [EVN_W-1:0]  nxt_evn,
    input  logic              nxt_cal,
    output logic              dec_valid,
    output logic [3:0]        dec,
    output logic [CNT_W-1:0]  skip_count,
    output logic [CNT_W-1:0]  pad_count
);
    localparam int unsigned LSB_W  = $clog2(WIN);
    localparam int unsigned N_CNT  = 2;

    logic      prev_step_ok;
    verdict_t  verdict_c;
    verdict_t  verdict_q;
    logic      valid_q;
    logic [N_CNT-1:0]       cnt_inc;
    logic [CNT_W-1:0]       cnt_val [N_CNT];

    evr_lsb_track #(.LSB_W(LSB_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .hdr_valid (hdr_valid),
        .cur_lsb   (cur_evn[LSB_W-1:0]),
        .step_ok   (prev_step_ok)
    );

    evr_decide #(.EVN_W(EVN_W), .WIN(WIN), .SYNC_W(SYNC_W)) u_decide (
        .sync_ctrl    (sync_ctrl),
        .loc_evn      (loc_evn),
        .loc_cal      (loc_cal),
        .cur_evn      (cur_evn),
        .nxt_evn      (nxt_evn),
        .nxt_cal      (nxt_cal),
        .prev_step_ok (prev_step_ok),
        .verdict      (verdict_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '{dec: DEC_NONE, why: WHY_NONE};
        end else begin
            valid_q   <= hdr_valid;
            verdict_q <= hdr_valid ? verdict_c : '{dec: DEC_NONE, why: WHY_NONE};
        end
    end

    assign cnt_inc[0] = hdr_valid && (verdict_c.dec == DEC_SKIP);
    assign cnt_inc[1] = hdr_valid && (verdict_c.dec == DEC_PAD);

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        evr_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    assign dec_valid  = valid_q;
    assign dec        = verdict_q.dec;
    assign skip_count = cnt_val[0];
    assign pad_count  = cnt_val[1];

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> ($countones(dec) == 1)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (dec == 4'b0000)); // R11
    AST_EXACT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && sync_ctrl == '0 && cur_evn == loc_evn) |=> (dec == 4'b0001)); // R2
    AST_MODE_OFF_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && sync_ctrl != '0) |=> (dec == 4'b0001)); // R9
    AST_SKIP_CNT_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (dec != 4'b0010) |-> $stable(skip_count)); // R10
    AST_PAD_CNT_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (dec != 4'b0100) |-> $stable(pad_count)); // R10

endmodule

// File: tb/evn_resync_tb_top.sv
module evn_resync_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 24;
    localparam int CW = 4;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   sync_ctrl = '0;
    logic          hdr_valid = 1'b0;
    logic [EW-1:0] loc_evn = '0;
    logic          loc_cal = 1'b0;
    logic [EW-1:0] cur_evn = '0;
    logic [EW-1:0] nxt_evn = '0;
    logic          nxt_cal = 1'b0;
    logic          dec_valid;
    logic [3:0]    dec;
    logic [CW-1:0] skip_count;
    logic [CW-1:0] pad_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [3:0]    m_prev_lsb = '0;
    bit            m_prev_ok  = 0;
    logic [CW-1:0] m_skip = '0;
    logic [CW-1:0] m_pad  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evn_resync #(.EVN_W(EW), .CNT_W(CW), .WIN(16), .SYNC_W(32)) dut_i (
        .clk(clk), .rst(rst), .sync_ctrl(sync_ctrl), .hdr_valid(hdr_valid),
        .loc_evn(loc_evn), .loc_cal(loc_cal), .cur_evn(cur_evn),
        .nxt_evn(nxt_evn), .nxt_cal(nxt_cal), .dec_valid(dec_valid),
        .dec(dec), .skip_count(skip_count), .pad_count(pad_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (loc=%0h cur=%0h nxt=%0h)",
                     req, act, exp, loc_evn, cur_evn, nxt_evn);
        end
    endtask

    // Apply one header; compares results one edge later, then one idle cycle.
    task automatic apply(input logic [EW-1:0] l, input logic lc, input logic [EW-1:0] c,
                         input logic [EW-1:0] n, input logic nc, input logic [31:0] s);
        logic [3:0]    exp_dec;
        string         tag;
        logic [EW-1:0] back;
        logic [EW-1:0] fwd;
        bit            prev_step;
        bit            nstep;
        loc_evn = l; loc_cal = lc; cur_evn = c; nxt_evn = n; nxt_cal = nc;
        sync_ctrl = s; hdr_valid = 1'b1;
        back      = l - n;
        fwd       = n - l;
        prev_step = m_prev_ok && (c[3:0] == 4'(m_prev_lsb + 1));
        nstep     = n[3:0] == 4'(c[3:0] + 1);
        if (s != 0)                              begin exp_dec = 4'b0001; tag = "R9"; end
        else if (c == l)                         begin exp_dec = 4'b0001; tag = "R2"; end
        else if (c[3:0] == l[3:0] && prev_step)  begin exp_dec = 4'b0001; tag = "R3"; end
        else if (nc != lc)                       begin exp_dec = 4'b0001; tag = "R4"; end
        else if (back < 16 && nstep)             begin exp_dec = 4'b0010; tag = "R5_R12"; end
        else if (fwd < 16 && nstep)              begin exp_dec = 4'b0100; tag = "R6_R12"; end
        else                                     begin exp_dec = 4'b1000; tag = "R7"; end
        m_prev_lsb = c[3:0];
        m_prev_ok  = 1;
        if (exp_dec == 4'b0010 && m_skip != CMAX) m_skip = m_skip + 1'b1;
        if (exp_dec == 4'b0100 && m_pad  != CMAX) m_pad  = m_pad + 1'b1;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R8", {31'd0, dec_valid}, 32'd1);
        check(tag, {28'd0, dec}, {28'd0, exp_dec});
        check("R10 skip", {28'd0, skip_count}, {28'd0, m_skip});
        check("R10 pad", {28'd0, pad_count}, {28'd0, m_pad});
        @(posedge clk);
        @(negedge clk);
        check("R11", {27'd0, dec_valid, dec}, 32'd0);
        check("R11 counts", {24'd0, skip_count, pad_count}, {24'd0, m_skip, m_pad});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", {27'd0, dec_valid, dec}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {27'd0, dec_valid, dec}, 32'd0);
        check("R1", {24'd0, skip_count, pad_count}, 32'd0);
        // first header after reset: LSB-step accept must not fire (R3)
        apply(24'h000020, 1'b0, 24'h000030, 24'h000050, 1'b0, 32'd0);

        for (int li = 0; li < 3; li++) begin
            for (int ci = 0; ci < 5; ci++) begin
                for (int no = -18; no <= 18; no++) begin
                    for (int cal = 0; cal < 2; cal++) begin
                        for (int pr = 0; pr < 2; pr++) begin
                            logic [EW-1:0] l;
                            logic [EW-1:0] c;
                            logic [EW-1:0] n;
                            int coff;
                            l = (li == 0) ? 24'h000005 : (li == 1) ? 24'hFFFFFE : 24'h123450;
                            coff = (ci == 0) ? 0 : (ci == 1) ? 16 : (ci == 2) ? -16 :
                                   (ci == 3) ? 1 : -3;
                            c = l + EW'(coff);
                            n = l + EW'(no);
                            if (pr == 1)
                                apply(l, 1'b0, c - 1'b1, l + 24'd100, 1'b0, 32'd0);
                            apply(l, 1'b0, c, n, cal[0], 32'd0);
                        end
                    end
                end
            end
        end

        // recovery disabled: always accept, counters frozen (R9)
        for (int k = -4; k <= 4; k++) begin
            apply(24'h000400, 1'b0, 24'h000400 + 24'd7, 24'h000400 + EW'(k), 1'b0, 32'h1 << (k + 4));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule